// File: doc/BRIEF.md
# Commit/Reconcile Cache Cell Controller

This block is the cache-side controller for a small array of cache cells under a commit/reconcile memory model. The processor presents one instruction at a time: local load, local store, commit or reconcile. Each cell is Invalid, Clean or Dirty. An instruction retires only when its cell is in a state that allows it. In any other state the controller does what brings the cell to such a state. It fetches on a miss, writes back on a commit to dirty data, and drops clean data on a reconcile. It keeps the instruction stalled until that work is done.

Requests leave through a one-entry output register with a valid/ready handshake: a fetch request or a writeback carrying the cell data. Replies come back as install messages with data or as writeback acknowledgements, and they are taken whenever they are valid. A cell with a request in flight is marked pending. Nothing further is issued for it, and nothing retires on it, until the reply lands.

Top module: `cr_cache_ctrl`

## Requirements
- R1: A load (proc_op 0) to a Clean or Dirty cell holds proc_ready high in the same cycle, and proc_rdata shows the cell's data. It sends no request.
- R2: A store (proc_op 1) to a Clean or Dirty cell retires at once. It writes proc_wdata into the cell and leaves the cell Dirty, and a later commit then sends a writeback.
- R3: A load or store to an Invalid cell keeps proc_ready low. It sends exactly one fetch request (req_kind 0) for that address and retires only after the install reply.
- R4: A commit (proc_op 2) to a Clean or Invalid cell retires at once and sends no request.
- R5: A commit to a Dirty cell sends one writeback (req_kind 1) whose req_data is the cell data. It retires after the acknowledgement.
- R6: A reconcile (proc_op 3) to a Dirty or Invalid cell retires at once and sends no request.
- R7: A reconcile to a Clean cell sends no request. It makes the cell Invalid and retires one cycle later, and the next load to that address fetches again.
- R8: An install reply (rsp_kind 0) writes rsp_data into the cell and makes it Clean. An acknowledgement (rsp_kind 1) makes the cell Clean and keeps its data.
- R9: While req_ready is low, req_valid, req_kind, req_addr and req_data hold steady. A pending cell never causes a second request.
- R10: During reset every cell is Invalid, req_valid is low, and a load is not ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| proc_valid | input | 1 | Instruction present |
| proc_op | input | 2 | 0 load, 1 store, 2 commit, 3 reconcile |
| proc_addr | input | ADDR_W | Cell address |
| proc_wdata | input | DATA_W | Store data |
| proc_ready | output | 1 | Instruction retires at this edge when valid |
| proc_rdata | output | DATA_W | Data of the addressed cell |
| req_valid | output | 1 | Request to memory present |
| req_ready | input | 1 | Memory takes the request |
| req_kind | output | 1 | 0 fetch, 1 writeback |
| req_addr | output | ADDR_W | Request address |
| req_data | output | DATA_W | Writeback data |
| rsp_valid | input | 1 | Reply present, consumed at this edge |
| rsp_kind | input | 1 | 0 install with data, 1 writeback acknowledge |
| rsp_addr | input | ADDR_W | Reply address |
| rsp_data | input | DATA_W | Install data |

## Verification
The assertions check on every cycle that a held request stays steady under backpressure and that issuing, purging and retiring never happen together. They also check that an issue always stalls the processor and shows up on the request port, and that a purge is followed by retirement. The bench's scenarios show the rest, because it depends on cell history: data from install and writeback, no message on retiring states, a refetch after a purge, the stall lengths, and a single request under a long backpressure stall.

// File: rtl/cr_pkg.sv
package cr_pkg;
  typedef enum logic [1:0] {OP_LOAD = 2'd0, OP_STORE = 2'd1, OP_COMMIT = 2'd2, OP_RECON = 2'd3} cr_op_e;
  typedef enum logic [1:0] {ST_INV = 2'd0, ST_CLEAN = 2'd1, ST_DIRTY = 2'd2} cr_state_e;

  localparam logic KIND_FETCH = 1'b0;
  localparam logic KIND_WB    = 1'b1;
  localparam logic RSP_INSTALL = 1'b0;
  localparam logic RSP_WBACK   = 1'b1;

  function automatic logic cr_retire_ok(cr_op_e op, cr_state_e st);
    case (op)
      OP_LOAD, OP_STORE: return st != ST_INV;
      OP_COMMIT:         return st != ST_DIRTY;
      default:           return st != ST_CLEAN;
    endcase
  endfunction

  function automatic logic cr_wants_fetch(cr_op_e op, cr_state_e st);
    return (op == OP_LOAD || op == OP_STORE) && st == ST_INV;
  endfunction

  function automatic logic cr_wants_wb(cr_op_e op, cr_state_e st);
    return op == OP_COMMIT && st == ST_DIRTY;
  endfunction

  function automatic logic cr_wants_purge(cr_op_e op, cr_state_e st);
    return op == OP_RECON && st == ST_CLEAN;
  endfunction
endpackage

// File: rtl/cr_cell_array.sv
module cr_cell_array
  import cr_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] pa_addr,
  output cr_state_e         pa_state,
  output logic [DATA_W-1:0] pa_data,
  output logic              pa_pend,
  input  logic              do_store,
  input  logic [DATA_W-1:0] store_data,
  input  logic              do_purge,
  input  logic              do_mark,
  input  logic              rsp_we,
  input  logic              rsp_is_ack,
  input  logic [ADDR_W-1:0] rsp_addr,
  input  logic [DATA_W-1:0] rsp_data
);
  localparam int NCELL = 1 << ADDR_W;

  cr_state_e         st_arr  [NCELL];
  logic [DATA_W-1:0] dat_arr [NCELL];
  logic              pend_arr[NCELL];

  generate
    for (genvar g = 0; g < NCELL; g++) begin : g_cell
      cr_state_e         st_q;
      logic [DATA_W-1:0] dat_q;
      logic              pend_q;
      logic              hit_p;
      logic              hit_r;

      assign hit_p = pa_addr == ADDR_W'(g);
      assign hit_r = rsp_we && rsp_addr == ADDR_W'(g);

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          st_q   <= ST_INV;
          dat_q  <= '0;
          pend_q <= 1'b0;
        end else if (hit_r) begin
          st_q   <= ST_CLEAN;
          pend_q <= 1'b0;
          if (!rsp_is_ack) dat_q <= rsp_data;
        end else if (hit_p) begin
          if (do_store) begin
            st_q  <= ST_DIRTY;
            dat_q <= store_data;
          end
          if (do_purge) st_q <= ST_INV;
          if (do_mark) pend_q <= 1'b1;
        end
      end

      assign st_arr[g]   = st_q;
      assign dat_arr[g]  = dat_q;
      assign pend_arr[g] = pend_q;
    end
  endgenerate

  assign pa_state = st_arr[pa_addr];
  assign pa_data  = dat_arr[pa_addr];
  assign pa_pend  = pend_arr[pa_addr];
endmodule

// File: rtl/cr_decide.sv
module cr_decide
  import cr_pkg::*;
(
  input  logic      valid,
  input  cr_op_e    op,
  input  cr_state_e st,
  input  logic      pend,
  input  logic      slot_free,
  output logic      can_retire,
  output logic      purge,
  output logic      issue,
  output logic      issue_wb
);
  logic live;
  logic need_msg;

  assign live       = valid && !pend;
  assign can_retire = !pend && cr_retire_ok(op, st);
  assign purge      = live && cr_wants_purge(op, st);
  assign issue_wb   = cr_wants_wb(op, st);
  assign need_msg   = cr_wants_fetch(op, st) || issue_wb;
  assign issue      = live && slot_free && need_msg;
endmodule

// File: rtl/cr_req_slot.sv
module cr_req_slot #(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              load_kind,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic [DATA_W-1:0] load_data,
  output logic              slot_free,
  output logic              req_valid,
  input  logic              req_ready,
  output logic              req_kind,
  output logic [ADDR_W-1:0] req_addr,
  output logic [DATA_W-1:0] req_data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_valid <= 1'b0;
      req_kind  <= 1'b0;
      req_addr  <= '0;
      req_data  <= '0;
    end else if (load) begin
      req_valid <= 1'b1;
      req_kind  <= load_kind;
      req_addr  <= load_addr;
      req_data  <= load_data;
    end else if (req_valid && req_ready) begin
      req_valid <= 1'b0;
    end
  end

  assign slot_free = !req_valid;
endmodule

// File: rtl/cr_cache_ctrl.sv
module cr_cache_ctrl
  import cr_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              proc_valid,
  input  logic [1:0]        proc_op,
  input  logic [ADDR_W-1:0] proc_addr,
  input  logic [DATA_W-1:0] proc_wdata,
  output logic              proc_ready,
  output logic [DATA_W-1:0] proc_rdata,
  output logic              req_valid,
  input  logic              req_ready,
  output logic              req_kind,
  output logic [ADDR_W-1:0] req_addr,
  output logic [DATA_W-1:0] req_data,
  input  logic              rsp_valid,
  input  logic              rsp_kind,
  input  logic [ADDR_W-1:0] rsp_addr,
  input  logic [DATA_W-1:0] rsp_data
);
  cr_op_e            op;
  cr_state_e         cell_st;
  logic [DATA_W-1:0] cell_dat;
  logic              cell_pend;
  logic              slot_free;
  logic              can_retire;
  logic              issue_wb;

  logic ev_retire;
  logic ev_purge;
  logic ev_issue;
  logic ev_store;

  assign op = cr_op_e'(proc_op);

  cr_cell_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cells (
    .clk        (clk),
    .rst_n      (rst_n),
    .pa_addr    (proc_addr),
    .pa_state   (cell_st),
    .pa_data    (cell_dat),
    .pa_pend    (cell_pend),
    .do_store   (ev_store),
    .store_data (proc_wdata),
    .do_purge   (ev_purge),
    .do_mark    (ev_issue),
    .rsp_we     (rsp_valid),
    .rsp_is_ack (rsp_kind == RSP_WBACK),
    .rsp_addr   (rsp_addr),
    .rsp_data   (rsp_data)
  );

  cr_decide u_decide (
    .valid      (proc_valid),
    .op         (op),
    .st         (cell_st),
    .pend       (cell_pend),
    .slot_free  (slot_free),
    .can_retire (can_retire),
    .purge      (ev_purge),
    .issue      (ev_issue),
    .issue_wb   (issue_wb)
  );

  cr_req_slot #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_slot (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (ev_issue),
    .load_kind (issue_wb ? KIND_WB : KIND_FETCH),
    .load_addr (proc_addr),
    .load_data (issue_wb ? cell_dat : '0),
    .slot_free (slot_free),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_kind  (req_kind),
    .req_addr  (req_addr),
    .req_data  (req_data)
  );

  assign proc_ready = can_retire;
  assign proc_rdata = cell_dat;
  assign ev_retire  = proc_valid && can_retire;
  assign ev_store   = ev_retire && op == OP_STORE;
endmodule

// File: rtl/cr_cache_ctrl_chk.sv
module cr_cache_ctrl_chk #(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              proc_valid,
  input logic              proc_ready,
  input logic [1:0]        proc_op,
  input logic [ADDR_W-1:0] proc_addr,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_kind,
  input logic [ADDR_W-1:0] req_addr,
  input logic [DATA_W-1:0] req_data,
  input logic              ev_retire,
  input logic              ev_purge,
  input logic              ev_issue
);
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_kind) && $stable(req_addr) && $stable(req_data)); // R9

  AST_EVENT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_retire, ev_purge, ev_issue})); // R7

  AST_ISSUE_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_issue |-> !proc_ready); // R3

  AST_ISSUE_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
    ev_issue |=> req_valid); // R9

  AST_PURGE_RETIRES: assert property (@(posedge clk) disable iff (!rst_n)
    ev_purge |=> (proc_ready || !proc_valid || proc_op != $past(proc_op) || proc_addr != $past(proc_addr))); // R7
endmodule

bind cr_cache_ctrl cr_cache_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .proc_valid (proc_valid),
  .proc_ready (proc_ready),
  .proc_op    (proc_op),
  .proc_addr  (proc_addr),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .req_kind   (req_kind),
  .req_addr   (req_addr),
  .req_data   (req_data),
  .ev_retire  (ev_retire),
  .ev_purge   (ev_purge),
  .ev_issue   (ev_issue)
);

// File: tb/tb_cr_cache_ctrl.sv
`timescale 1ns/1ps
module tb_cr_cache_ctrl;
  localparam int ADDR_W = 2;
  localparam int DATA_W = 8;
  localparam int NVEC = 19;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              proc_valid = 1'b0;
  logic [1:0]        proc_op = 2'd0;
  logic [ADDR_W-1:0] proc_addr = '0;
  logic [DATA_W-1:0] proc_wdata = '0;
  logic              proc_ready;
  logic [DATA_W-1:0] proc_rdata;
  logic              req_valid;
  logic              req_ready = 1'b1;
  logic              req_kind;
  logic [ADDR_W-1:0] req_addr;
  logic [DATA_W-1:0] req_data;
  logic              rsp_valid = 1'b0;
  logic              rsp_kind = 1'b0;
  logic [ADDR_W-1:0] rsp_addr = '0;
  logic [DATA_W-1:0] rsp_data = '0;

  int n_chk = 0;
  int n_bad = 0;
  int n_fetch = 0;
  int n_wb = 0;
  int bp_left = 0;
  int bp_seen = 0;
  bit done = 0;
  logic [DATA_W-1:0] mem [1 << ADDR_W];

  always #4 clk = ~clk;

  cr_cache_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut (.*);

  // op, addr, store data, expected load data, expected message (0 none, 1 fetch, 2 wb), stall cycles
  localparam logic [23:0] VEC [NVEC] = '{
    {2'd0, 2'd1, 8'h00, 8'hA1, 2'd1, 2'd3},
    {2'd0, 2'd1, 8'h00, 8'hA1, 2'd0, 2'd0},
    {2'd1, 2'd1, 8'h55, 8'h00, 2'd0, 2'd0},
    {2'd0, 2'd1, 8'h00, 8'h55, 2'd0, 2'd0},
    {2'd3, 2'd1, 8'h00, 8'h00, 2'd0, 2'd0},
    {2'd0, 2'd1, 8'h00, 8'h55, 2'd0, 2'd0},
    {2'd2, 2'd1, 8'h00, 8'h00, 2'd2, 2'd3},
    {2'd2, 2'd1, 8'h00, 8'h00, 2'd0, 2'd0},
    {2'd0, 2'd1, 8'h00, 8'h55, 2'd0, 2'd0},
    {2'd3, 2'd1, 8'h00, 8'h00, 2'd0, 2'd1},
    {2'd0, 2'd1, 8'h00, 8'h55, 2'd1, 2'd3},
    {2'd1, 2'd2, 8'h77, 8'h00, 2'd1, 2'd3},
    {2'd0, 2'd2, 8'h00, 8'h77, 2'd0, 2'd0},
    {2'd2, 2'd3, 8'h00, 8'h00, 2'd0, 2'd0},
    {2'd3, 2'd3, 8'h00, 8'h00, 2'd0, 2'd0},
    {2'd2, 2'd2, 8'h00, 8'h00, 2'd2, 2'd3},
    {2'd3, 2'd2, 8'h00, 8'h00, 2'd0, 2'd1},
    {2'd0, 2'd2, 8'h00, 8'h77, 2'd1, 2'd3},
    {2'd0, 2'd0, 8'h00, 8'hA0, 2'd1, 2'd3}
  };

  function automatic string tag_of(logic [1:0] op, logic [1:0] msg, logic [1:0] stall);
    case (op)
      2'd0:    return (msg == 2'd1) ? "R3" : "R1";
      2'd1:    return (msg == 2'd1) ? "R3" : "R2";
      2'd2:    return (msg == 2'd2) ? "R5" : "R4";
      default: return (stall == 2'd1) ? "R7" : "R6";
    endcase
  endfunction

  task automatic check(string tag, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // memory responder: accepts a request at a negedge, replies one cycle after the transfer
  initial begin
    bit have = 0;
    logic kind_h = 1'b0;
    logic [ADDR_W-1:0] addr_h = '0;
    for (int i = 0; i < (1 << ADDR_W); i++) mem[i] = 8'hA0 + 8'(i);
    forever begin
      @(negedge clk);
      rsp_valid = 1'b0;
      if (have) begin
        rsp_valid = 1'b1;
        rsp_kind  = kind_h;
        rsp_addr  = addr_h;
        rsp_data  = kind_h ? 8'h00 : mem[addr_h];
        have = 0;
      end
      if (req_valid && bp_left > 0) begin
        req_ready = 1'b0;
        bp_left--;
        bp_seen++;
      end else begin
        req_ready = 1'b1;
        if (req_valid) begin
          kind_h = req_kind;
          addr_h = req_addr;
          if (req_kind) begin
            mem[req_addr] = req_data;
            n_wb++;
          end else begin
            n_fetch++;
          end
          have = 1;
        end
      end
    end
  end

  task automatic do_op(input logic [1:0] op, input logic [ADDR_W-1:0] addr,
                       input logic [DATA_W-1:0] wd, output logic [DATA_W-1:0] rd, output int stall);
    @(negedge clk);
    proc_valid = 1'b1;
    proc_op    = op;
    proc_addr  = addr;
    proc_wdata = wd;
    stall = 0;
    #1;
    while (!proc_ready && stall < 400) begin
      @(negedge clk);
      #1;
      stall++;
    end
    rd = proc_rdata;
    @(posedge clk);
    #1;
    proc_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [DATA_W-1:0] rd;
    int st;
    int f0;
    int w0;
    // R10: reset state, observed while reset is held
    repeat (2) @(negedge clk);
    proc_valid = 1'b1;
    proc_op = 2'd0;
    proc_addr = 2'd0;
    #1;
    check("R10", "req_valid in reset", int'(req_valid), 0);
    check("R10", "load ready in reset", int'(proc_ready), 0);
    proc_op = 2'd2;
    #1;
    check("R10", "commit ready on Invalid in reset", int'(proc_ready), 1);
    proc_valid = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;

    for (int v = 0; v < NVEC; v++) begin
      logic [1:0] op;
      logic [1:0] msg;
      logic [1:0] stl;
      string t;
      op  = VEC[v][23:22];
      msg = VEC[v][3:2];
      stl = VEC[v][1:0];
      t   = tag_of(op, msg, stl);
      f0 = n_fetch;
      w0 = n_wb;
      do_op(op, VEC[v][21:20], VEC[v][19:12], rd, st);
      @(negedge clk);
      check(t, $sformatf("vec %0d fetch count", v), n_fetch - f0, (msg == 2'd1) ? 1 : 0);
      check(t, $sformatf("vec %0d wb count", v), n_wb - w0, (msg == 2'd2) ? 1 : 0);
      check(t, $sformatf("vec %0d stall", v), st, int'(stl));
      if (op == 2'd0) check(t, $sformatf("vec %0d load data", v), int'(rd), int'(VEC[v][11:4]));
    end

    // R5: writebacks carried the cell data into memory
    check("R5", "mem[1] after writeback", int'(mem[1]), 'h55);
    check("R5", "mem[2] after writeback", int'(mem[2]), 'h77);

    // R8: install after a purge brings back memory data; ack kept data (load on Clean, no message)
    f0 = n_fetch;
    do_op(2'd0, 2'd2, 8'h00, rd, st);
    check("R8", "clean load after install", int'(rd), 'h77);
    check("R8", "no refetch on Clean", n_fetch - f0, 0);

    // R9: long backpressure, one request only, held until taken
    bp_seen = 0;
    bp_left = 6;
    f0 = n_fetch;
    do_op(2'd1, 2'd3, 8'h3C, rd, st);
    @(negedge clk);
    check("R9", "single fetch under backpressure", n_fetch - f0, 1);
    check("R9", "backpressure cycles observed", bp_seen, 6);
    check("R9", "stall grows with backpressure", st, 9);
    do_op(2'd0, 2'd3, 8'h00, rd, st);
    check("R2", "store after fetch visible", int'(rd), 'h3C);
    w0 = n_wb;
    do_op(2'd2, 2'd3, 8'h00, rd, st);
    @(negedge clk);
    check("R2", "store left cell Dirty", n_wb - w0, 1);
    check("R5", "writeback data", int'(mem[3]), 'h3C);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule